// File: doc/BRIEF.md
# Packet Message Encoder with CRC-8

This block turns a staged payload into a framed outbound packet for a host link. A register-bus master first writes payload bytes into a small internal FIFO. It then pulses a start command together with a target address and a packet kind, which is either reply or status. The encoder sends out a start marker, the address, a type code, a length byte, the payload bytes in the order they were written, and a CRC-8 trailer. The bytes go to a downstream UART transmitter one at a time over a valid/ready handshake.

The packet is sequenced by a state machine with seven states: IDLE, SOF, ADDR, TYPE, LEN, DATA and CRC. The transitions are as follows:
- IDLE to SOF happens on a start command. At that point the address, the type code and the FIFO occupancy are captured, and the CRC register is cleared.
- SOF to ADDR, ADDR to TYPE and TYPE to LEN each happen when the current byte is accepted.
- LEN goes to DATA when the length is non-zero, and straight to CRC when it is zero.
- DATA goes to CRC when the last counted payload byte is accepted.
- CRC goes back to IDLE when the trailer is accepted.

While the state machine is out of IDLE, the block reports busy. During that time it refuses FIFO writes and ignores further start commands.

Top module: `pkt_encoder`

## Requirements
- R1: After reset, `busy` and `tx_valid` are 0 and `wr_ready` is 1.
- R2: A packet is emitted as the start marker (parameter `SOF_BYTE`, default 0x7E), then the captured address, type, length, payload, and finally the CRC byte.
- R3: The type byte is 0x07 when `pkt_kind` is 0 (reply) and 0x18 when `pkt_kind` is 1 (status).
- R4: The length byte equals the FIFO occupancy at the start command, capped at 255. A length of 0 is followed directly by the CRC byte.
- R5: The CRC byte uses the polynomial 0xD5 (x^8+x^7+x^6+x^4+x^2+1) with an initial value of 0x00. It is computed MSB first over the address, type, length and payload bytes.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value into the next cycle.
- R7: `busy` rises in the cycle after an accepted start command. It stays high until the CRC byte is accepted and is 0 in the cycle after that.
- R8: A start command while `busy` is high has no effect. The packet in flight is unchanged, and no further packet follows it.
- R9: While `busy` is high, `wr_ready` is 0 and a write is dropped, so the dropped byte never appears in a later packet.
- R10: When the FIFO holds `DEPTH` entries (default 16), `wr_ready` is 0 and further writes are dropped.
- R11: Payload bytes leave in the order they were written, and the FIFO is empty once the packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Payload write request |
| wr_data | input | 8 | Payload byte to stage |
| wr_ready | output | 1 | Write is taken this cycle (idle and FIFO not full) |
| pkt_addr | input | 8 | Address field, sampled at start |
| pkt_kind | input | 1 | 0 = reply, 1 = status, sampled at start |
| go | input | 1 | Start command, one-cycle pulse |
| busy | output | 1 | Packet in progress |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The assertions assume that every input is synchronous to `clk`, and that the transmitter drops `tx_ready` only while it genuinely cannot take a byte. They do not assume that `go` or `wr_en` stay quiet while busy: both may be pulsed at any time. The bench drives every input on the falling edge, so all values are settled before the rising edge. On purpose, it sends a start command and a write in the middle of a packet, and it applies a ready pattern that stalls each byte for two cycles. It also fills the FIFO past its capacity. None of this stimulus depends on a default that the assertions would need to rule out.

// File: rtl/pkt_enc_pkg.sv
package pkt_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_ADDR,
        ST_TYPE,
        ST_LEN,
        ST_DATA,
        ST_CRC
    } enc_state_t;

    localparam logic [7:0] TYPE_REPLY  = 8'h07;
    localparam logic [7:0] TYPE_STATUS = 8'h18;
    localparam logic [7:0] CRC_POLY    = 8'hD5;

    // One byte of CRC-8, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] b);
        logic [7:0] c;
        c = crc_in ^ b;
        for (int i = 0; i < 8; i++) begin
            if (c[7]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else      c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_byte_fifo.sv
module pkt_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    output logic [7:0]       dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pkt_crc8.sv
module pkt_crc8
    import pkt_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= '0;
        else if (clear) crc <= '0;
        else if (en)    crc <= crc8_step(crc, din);
    end

endmodule

// File: rtl/pkt_frame_fsm.sv
module pkt_frame_fsm
    import pkt_enc_pkg::*;
#(
    parameter int         CNT_W    = 5,
    parameter logic [7:0] SOF_BYTE = 8'h7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       addr_in,
    input  logic             kind_in,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [7:0]       fifo_dout,
    input  logic [7:0]       crc_val,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             busy,
    output logic             fifo_pop,
    output logic             crc_clear,
    output logic             crc_en
);

    enc_state_t state_q, state_d;
    logic [7:0] addr_q, type_q, len_q, rem_q;
    logic       accept, start_ok;
    logic [15:0] cnt_ext;
    logic [7:0]  len_cap;

    assign accept   = tx_valid && tx_ready;
    assign start_ok = (state_q == ST_IDLE) && go;
    assign cnt_ext  = 16'(fifo_count);
    assign len_cap  = (cnt_ext > 16'd255) ? 8'hFF : cnt_ext[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            type_q <= '0;
            len_q  <= '0;
            rem_q  <= '0;
        end else if (start_ok) begin
            addr_q <= addr_in;
            type_q <= kind_in ? TYPE_STATUS : TYPE_REPLY;
            len_q  <= len_cap;
            rem_q  <= len_cap;
        end else if (state_q == ST_DATA && accept) begin
            rem_q  <= rem_q - 8'd1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)     state_d = ST_SOF;
            ST_SOF:  if (accept) state_d = ST_ADDR;
            ST_ADDR: if (accept) state_d = ST_TYPE;
            ST_TYPE: if (accept) state_d = ST_LEN;
            ST_LEN:  if (accept) state_d = (len_q == 8'd0) ? ST_CRC : ST_DATA;
            ST_DATA: if (accept && rem_q == 8'd1) state_d = ST_CRC;
            ST_CRC:  if (accept) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = (state_q != ST_IDLE);
        busy     = (state_q != ST_IDLE);
        tx_data  = 8'h00;
        unique case (state_q)
            ST_SOF:  tx_data = SOF_BYTE;
            ST_ADDR: tx_data = addr_q;
            ST_TYPE: tx_data = type_q;
            ST_LEN:  tx_data = len_q;
            ST_DATA: tx_data = fifo_dout;
            ST_CRC:  tx_data = crc_val;
            default: tx_data = 8'h00;
        endcase
        fifo_pop  = (state_q == ST_DATA) && accept;
        crc_clear = start_ok;
        crc_en    = accept && (state_q == ST_ADDR || state_q == ST_TYPE ||
                               state_q == ST_LEN  || state_q == ST_DATA);
    end

    a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    a_r7_busy_ends_on_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(state_q == ST_CRC && tx_ready));
    a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && go |=> $stable(addr_q) && $stable(type_q) && $stable(len_q));
    a_r4_zero_len_skips_data: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LEN && accept && len_q == 8'd0 |=> state_q == ST_CRC);

endmodule

// File: rtl/pkt_encoder.sv
module pkt_encoder #(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] SOF_BYTE = 8'h7E,
    localparam int        CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic [7:0] pkt_addr,
    input  logic       pkt_kind,
    input  logic       go,
    output logic       busy,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready
);

    logic             push, pop, full, empty, crc_clear, crc_en;
    logic [7:0]       fifo_dout, crc_val;
    logic [CNT_W-1:0] fifo_count;

    assign wr_ready = !busy && !full;
    assign push     = wr_en && wr_ready;

    pkt_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_data),
        .pop   (pop),
        .dout  (fifo_dout),
        .full  (full),
        .empty (empty),
        .count (fifo_count)
    );

    pkt_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .en    (crc_en),
        .din   (tx_data),
        .crc   (crc_val)
    );

    pkt_frame_fsm #(.CNT_W(CNT_W), .SOF_BYTE(SOF_BYTE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .addr_in    (pkt_addr),
        .kind_in    (pkt_kind),
        .fifo_count (fifo_count),
        .fifo_dout  (fifo_dout),
        .crc_val    (crc_val),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .busy       (busy),
        .fifo_pop   (pop),
        .crc_clear  (crc_clear),
        .crc_en     (crc_en)
    );

    a_r9_count_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> fifo_count <= $past(fifo_count));

endmodule

// File: tb/pkt_encoder_bench.sv
module pkt_encoder_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         DEPTH      = 16;
    localparam logic [7:0] SOF        = 8'h7E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic [7:0] pkt_addr = '0;
    logic       pkt_kind = 1'b0;
    logic       go = 1'b0;
    logic       busy;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;

    int total = 0;
    int bad   = 0;
    logic [7:0] model_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_encoder #(.DEPTH(DEPTH), .SOF_BYTE(SOF)) u_pkt_encoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .pkt_addr(pkt_addr), .pkt_kind(pkt_kind),
        .go(go), .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'hD5 : 8'h00);
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            logic acc = (model_q.size() < DEPTH);
            wr_en = 1'b1;
            wr_data = base + 8'(i);
            check(acc ? "R10 wr_ready open" : "R10 wr_ready full", int'(wr_ready), int'(acc));
            if (acc) model_q.push_back(wr_data);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic run_pkt(input logic [7:0] a, input logic k, input bit stall, input bit poke);
        logic [7:0] exp[$];
        logic [7:0] c = 8'h00;
        int idx = 0;
        int cyc = 0;
        bit held = 0;
        bit poked = 0;
        logic [7:0] hold_val = '0;
        exp.push_back(SOF);
        exp.push_back(a);
        exp.push_back(k ? 8'h18 : 8'h07);
        exp.push_back(8'(model_q.size()));
        foreach (model_q[i]) exp.push_back(model_q[i]);
        for (int i = 1; i < exp.size(); i++) c = ref_crc(c, exp[i]);
        exp.push_back(c);
        pkt_addr = a;
        pkt_kind = k;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R7 busy after start", int'(busy), 1);
        while (idx < exp.size()) begin
            tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (poke && idx == 2 && !poked) begin
                poked = 1;
                wr_en = 1'b1;
                wr_data = 8'hEE;
                go = 1'b1;
                pkt_addr = 8'h99;
                pkt_kind = ~k;
                check("R9 wr_ready low while busy", int'(wr_ready), 0);
            end
            if (held) check("R6 byte held under stall", int'(tx_data), int'(hold_val));
            held = 0;
            if (tx_valid && tx_ready) begin
                if (idx < 2)                 check("R2 marker/address", int'(tx_data), int'(exp[idx]));
                else if (idx == 2)           check("R3 type code", int'(tx_data), int'(exp[idx]));
                else if (idx == 3)           check("R4 length", int'(tx_data), int'(exp[idx]));
                else if (idx == exp.size()-1) check("R5 crc", int'(tx_data), int'(exp[idx]));
                else                         check("R11 payload order", int'(tx_data), int'(exp[idx]));
                idx++;
            end else if (tx_valid) begin
                held = 1;
                hold_val = tx_data;
            end else begin
                check("R7 valid during packet", 0, 1);
            end
            @(negedge clk);
            wr_en = 1'b0;
            go = 1'b0;
            cyc++;
        end
        tx_ready = 1'b0;
        check("R7 busy clear after crc", int'(busy), 0);
        check("R7 valid clear after crc", int'(tx_valid), 0);
        model_q.delete();
    endtask

    task automatic t_reset();
        check("R1 busy at reset", int'(busy), 0);
        check("R1 valid at reset", int'(tx_valid), 0);
        check("R1 wr_ready at reset", int'(wr_ready), 1);
    endtask

    task automatic t_reply();
        push_bytes(4, 8'h10);
        run_pkt(8'h3C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_status_stall();
        push_bytes(3, 8'hA0);
        run_pkt(8'h05, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_busy_ignore();
        push_bytes(2, 8'h55);
        run_pkt(8'h21, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            check("R8 no second packet", int'(busy), 0);
            @(negedge clk);
        end
        run_pkt(8'h40, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_full();
        push_bytes(DEPTH + 2, 8'hC0);
        check("R10 wr_ready low when full", int'(wr_ready), 0);
        run_pkt(8'hFF, 1'b1, 1'b1, 1'b0);
        check("R11 fifo drained", int'(wr_ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reply();
        t_status_stall();
        t_busy_ignore();
        t_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule